// File: doc/BRIEF.md
# Misaligned Load/Store Byte-Lane Bus Bridge

This block connects a processor's load/store request port to a 32-bit memory bus built from four byte-wide banks. A request names a byte address, a size (one, two or four bytes), a direction, a memory-or-I/O space flag and, for stores, the data right-justified. The bridge turns each request into one or two bus cycles. Every bus cycle carries an address that is a multiple of the lane count and a byte-enable mask, one bit per bank. Stores have their bytes rotated onto the lanes they belong to. Load bytes are collected from the lanes, put back in little-endian order and returned right-justified.

An access whose bytes all fall inside one aligned 4-byte group uses a single bus cycle. An access that runs past the end of its group is split. The lower group is transferred first and the following group second. Each bus cycle is held until the memory acknowledges it. When the last acknowledge arrives, the bridge returns to idle and gives a one-cycle completion pulse.

Top module: `lane_bus_if`

## Requirements
- R1: While a bus cycle is active (a strobe is low), the two low bits of `bus_addr` are zero.
- R2: Bit i of `bus_be` enables lane i, which is `bus_wdata`/`bus_rdata` bits [8i+7:8i]. Byte address A is carried on lane A mod 4. Size code 0 is one byte and always completes in one bus cycle. At least one enable bit is set in every active cycle.
- R3: Size code 1 is two bytes. It takes one bus cycle unless the address mod 4 is 3, in which case it takes two.
- R4: Size codes 2 and 3 both mean four bytes. Such an access takes one bus cycle when the address mod 4 is 0 and two bus cycles otherwise.
- R5: A split access first uses the aligned address at or below the request address, with the enables from the offset upward. It then uses that address plus 4, with only the remaining low lanes enabled.
- R6: On a store, byte k of `req_wdata` (bits [8k+7:8k]) is driven on the lane and in the cycle that address+k maps to.
- R7: On a load, byte k of `done_rdata` is the memory byte at address+k, for k below the size. All higher bytes are zero, whatever the disabled lanes carry. A store completes with `done_rdata` equal to zero.
- R8: `bus_rd_n` and `bus_wr_n` are active low. Both are high when no cycle is active, and they are never low together. A load drives only `bus_rd_n` low and a store only `bus_wr_n`.
- R9: Address, enables, strobes and write data stay unchanged from cycle to cycle until `bus_ack` is seen high at a clock edge.
- R10: `req_ready` is high exactly when idle. A request is taken when `req_valid` and `req_ready` are both high. `done` is high for exactly one cycle, the cycle after the final acknowledge, with `done_rdata` valid in that cycle.
- R11: An I/O request drives `bus_io` high in its cycles. In those cycles, `bus_addr` bits above bit 15 are zero.
- R12: After reset, `req_ready` is high, both strobes are high, `bus_be` is zero and `done` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Bridge idle, request may be taken |
| req_write | input | 1 | 1 = store, 0 = load |
| req_io | input | 1 | 1 = I/O space, 0 = memory space |
| req_size | input | 2 | 0 byte, 1 two bytes, 2/3 four bytes |
| req_addr | input | ADDR_W | Byte address, any alignment |
| req_wdata | input | DATA_W | Store data, right-justified |
| done | output | 1 | One-cycle completion pulse |
| done_rdata | output | DATA_W | Load result, right-justified, zero-filled |
| bus_addr | output | ADDR_W | Aligned bus address |
| bus_be | output | DATA_W/8 | Per-lane byte enables, active high |
| bus_rd_n | output | 1 | Read strobe, active low |
| bus_wr_n | output | 1 | Write strobe, active low |
| bus_io | output | 1 | I/O space select |
| bus_wdata | output | DATA_W | Lane-steered store data |
| bus_rdata | input | DATA_W | Lane data from memory |
| bus_ack | input | 1 | Memory accepts/finishes the current cycle |

## Verification
A bad sequencing state shows up at the ports in the very next cycle. The symptoms are a strobe that stays low after the last acknowledge, a second cycle that is missing or extra, or a `done` pulse that comes early or late. A wrongly latched offset or size shows up in the first active cycle as a wrong enable mask or a wrongly rotated store lane. A corrupted low-half holding register only surfaces at the completion pulse of a split load, as bytes out of order or not zeroed. For this reason, split loads run with junk on the disabled lanes and with varying acknowledge delays.

// File: rtl/lbi_pkg.sv
package lbi_pkg;
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_FIRST  = 2'd1,
    ST_SECOND = 2'd2
  } lbi_state_e;
endpackage

// File: rtl/lbi_plan.sv
// Lane planner: turns byte offset and size into the enables of both
// possible bus cycles and rotates store data onto the lanes.
module lbi_plan #(
  parameter int LANES  = 4,
  parameter int DATA_W = LANES * 8
) (
  input  logic [$clog2(LANES)-1:0] ofs,
  input  logic [1:0]               size,
  input  logic [DATA_W-1:0]        wdata,
  output logic [LANES-1:0]         be_lo,
  output logic [LANES-1:0]         be_hi,
  output logic                     split,
  output logic [DATA_W-1:0]        wd_lo,
  output logic [DATA_W-1:0]        wd_hi
);
  localparam int OFS_W = $clog2(LANES);

  logic [2:0]          nbytes;
  logic [LANES:0]      run;
  logic [2*LANES-1:0]  span;
  logic [2*DATA_W-1:0] wide;

  always_comb begin
    unique case (size)
      2'd0:    nbytes = 3'd1;
      2'd1:    nbytes = 3'd2;
      default: nbytes = 3'd4;
    endcase
    run  = ({{LANES{1'b0}}, 1'b1} << nbytes) - {{LANES{1'b0}}, 1'b1};
    span = {{LANES{1'b0}}, run[LANES-1:0]} << ofs;
    wide = {{DATA_W{1'b0}}, wdata} << {ofs, 3'b000};
  end

  assign be_lo = span[LANES-1:0];
  assign be_hi = span[2*LANES-1:LANES];
  assign split = |be_hi;
  assign wd_lo = wide[DATA_W-1:0];
  assign wd_hi = wide[2*DATA_W-1:DATA_W];

  // unused-width guard for OFS_W
  logic unused_ok;
  assign unused_ok = (OFS_W > 0);
endmodule

// File: rtl/lbi_gather.sv
// Read reassembly: zeroes lanes that are not enabled, joins the halves
// of a split access and shifts the result down to bit 0.
module lbi_gather #(
  parameter int LANES  = 4,
  parameter int DATA_W = LANES * 8
) (
  input  logic [LANES-1:0]         be,
  input  logic [DATA_W-1:0]        lane_in,
  input  logic [DATA_W-1:0]        lo_keep,
  input  logic                     second,
  input  logic [$clog2(LANES)-1:0] ofs,
  output logic [DATA_W-1:0]        lane_kept,
  output logic [DATA_W-1:0]        result
);
  logic [2*DATA_W-1:0] joined;
  logic [2*DATA_W-1:0] shifted;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign lane_kept[8*g +: 8] = be[g] ? lane_in[8*g +: 8] : 8'h00;
  end

  always_comb begin
    joined  = second ? {lane_kept, lo_keep} : {{DATA_W{1'b0}}, lane_kept};
    shifted = joined >> {ofs, 3'b000};
    result  = shifted[DATA_W-1:0];
  end
endmodule

// File: rtl/lane_bus_if.sv
module lane_bus_if #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int IO_AW  = 16
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  req_valid,
  output logic                  req_ready,
  input  logic                  req_write,
  input  logic                  req_io,
  input  logic [1:0]            req_size,
  input  logic [ADDR_W-1:0]     req_addr,
  input  logic [DATA_W-1:0]     req_wdata,
  output logic                  done,
  output logic [DATA_W-1:0]     done_rdata,
  output logic [ADDR_W-1:0]     bus_addr,
  output logic [DATA_W/8-1:0]   bus_be,
  output logic                  bus_rd_n,
  output logic                  bus_wr_n,
  output logic                  bus_io,
  output logic [DATA_W-1:0]     bus_wdata,
  input  logic [DATA_W-1:0]     bus_rdata,
  input  logic                  bus_ack
);
  import lbi_pkg::*;

  localparam int LANES = DATA_W / 8;
  localparam int OFS_W = $clog2(LANES);
  localparam logic [ADDR_W-1:0] IO_MASK  = ADDR_W'((64'd1 << IO_AW) - 64'd1);
  localparam logic [ADDR_W-1:0] STEP     = ADDR_W'(LANES);

  lbi_state_e          state_q, state_d;
  logic [ADDR_W-1:0]   base_q;
  logic [OFS_W-1:0]    ofs_q;
  logic [1:0]          size_q;
  logic                wr_q, io_q;
  logic [DATA_W-1:0]   wdata_q;
  logic [DATA_W-1:0]   lo_keep_q;
  logic [DATA_W-1:0]   rdata_q;
  logic                done_q, done_d;

  logic                accept, active, second;
  logic                keep_en, rdata_en;
  logic [LANES-1:0]    be_lo, be_hi, cur_be, rd_be;
  logic                split;
  logic [DATA_W-1:0]   wd_lo, wd_hi, lane_kept, gathered;
  logic [ADDR_W-1:0]   cyc_addr;

  lbi_plan #(.LANES(LANES), .DATA_W(DATA_W)) u_plan (
    .ofs   (ofs_q),
    .size  (size_q),
    .wdata (wdata_q),
    .be_lo (be_lo),
    .be_hi (be_hi),
    .split (split),
    .wd_lo (wd_lo),
    .wd_hi (wd_hi)
  );

  assign accept = req_valid && (state_q == ST_IDLE);
  assign active = (state_q != ST_IDLE);
  assign second = (state_q == ST_SECOND);
  assign cur_be = second ? be_hi : be_lo;
  assign rd_be  = wr_q ? '0 : cur_be;

  lbi_gather #(.LANES(LANES), .DATA_W(DATA_W)) u_gather (
    .be        (rd_be),
    .lane_in   (bus_rdata),
    .lo_keep   (lo_keep_q),
    .second    (second),
    .ofs       (ofs_q),
    .lane_kept (lane_kept),
    .result    (gathered)
  );

  // next-state process
  always_comb begin
    state_d  = state_q;
    done_d   = 1'b0;
    keep_en  = 1'b0;
    rdata_en = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (req_valid) state_d = ST_FIRST;
      end
      ST_FIRST: begin
        if (bus_ack) begin
          if (split) begin
            state_d = ST_SECOND;
            keep_en = 1'b1;
          end else begin
            state_d  = ST_IDLE;
            done_d   = 1'b1;
            rdata_en = 1'b1;
          end
        end
      end
      ST_SECOND: begin
        if (bus_ack) begin
          state_d  = ST_IDLE;
          done_d   = 1'b1;
          rdata_en = 1'b1;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  // register process
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      base_q    <= '0;
      ofs_q     <= '0;
      size_q    <= '0;
      wr_q      <= 1'b0;
      io_q      <= 1'b0;
      wdata_q   <= '0;
      lo_keep_q <= '0;
      rdata_q   <= '0;
      done_q    <= 1'b0;
    end else begin
      state_q <= state_d;
      done_q  <= done_d;
      if (accept) begin
        base_q  <= {req_addr[ADDR_W-1:OFS_W], {OFS_W{1'b0}}};
        ofs_q   <= req_addr[OFS_W-1:0];
        size_q  <= req_size;
        wr_q    <= req_write;
        io_q    <= req_io;
        wdata_q <= req_wdata;
      end
      if (keep_en)  lo_keep_q <= lane_kept;
      if (rdata_en) rdata_q   <= gathered;
    end
  end

  always_comb begin
    cyc_addr = base_q + (second ? STEP : '0);
    if (io_q) cyc_addr = cyc_addr & IO_MASK;
  end

  assign req_ready  = !active;
  assign done       = done_q;
  assign done_rdata = rdata_q;
  assign bus_addr   = active ? cyc_addr : '0;
  assign bus_be     = active ? cur_be : '0;
  assign bus_rd_n   = !(active && !wr_q);
  assign bus_wr_n   = !(active && wr_q);
  assign bus_io     = active && io_q;
  assign bus_wdata  = second ? wd_hi : wd_lo;

  // ---------------- assertions ----------------
  p_aligned_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_rd_n && bus_wr_n) |-> (bus_addr[OFS_W-1:0] == '0));

  p_be_present_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_rd_n && bus_wr_n) |-> (bus_be != '0));

  p_second_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_FIRST && bus_ack && split && !bus_io)
      |=> (bus_addr == $past(bus_addr) + STEP));

  p_one_strobe_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd_n || bus_wr_n));

  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!(bus_rd_n && bus_wr_n) && !bus_ack)
      |=> ($stable(bus_addr) && $stable(bus_be) && $stable(bus_rd_n)
           && $stable(bus_wr_n) && $stable(bus_wdata)));

  p_done_after_ack_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ($past(bus_ack) && req_ready));

  p_ready_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (bus_rd_n && bus_wr_n && bus_be == '0));

  p_io_window_r11: assert property (@(posedge clk) disable iff (!rst_n)
    bus_io |-> ((bus_addr & ~IO_MASK) == '0));
endmodule

// File: tb/lane_bus_if_bench.sv
module lane_bus_if_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid, req_write, req_io;
  logic [1:0]  req_size;
  logic [31:0] req_addr, req_wdata;
  logic        req_ready, done;
  logic [31:0] done_rdata, bus_addr, bus_wdata, bus_rdata;
  logic [3:0]  bus_be;
  logic        bus_rd_n, bus_wr_n, bus_io, bus_ack;

  int vectors = 0;
  int errors  = 0;
  bit finished = 0;
  logic [7:0] mem [0:255];

  always #2.5 clk = ~clk;

  lane_bus_if u_lane_bus_if (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_io(req_io), .req_size(req_size), .req_addr(req_addr),
    .req_wdata(req_wdata), .done(done), .done_rdata(done_rdata),
    .bus_addr(bus_addr), .bus_be(bus_be), .bus_rd_n(bus_rd_n),
    .bus_wr_n(bus_wr_n), .bus_io(bus_io), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .bus_ack(bus_ack)
  );

  task automatic chk(input string msg, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", msg, act, exp);
    end
  endtask

  // One request, checked bus cycle by bus cycle against a behavioural model.
  task automatic xfer(input bit wr, input bit io, input logic [1:0] sz,
                      input logic [31:0] addr, input logic [31:0] wd, input int waitn);
    int nb, ofs, ncyc, rel;
    logic [31:0] exp_rd, ea, exp_be;
    logic [7:0]  idx;
    string ctag;
    nb   = (sz == 2'd0) ? 1 : (sz == 2'd1) ? 2 : 4;
    ofs  = int'(addr[1:0]);
    ncyc = (ofs + nb > 4) ? 2 : 1;
    ctag = (sz == 2'd0) ? "R2" : (sz == 2'd1) ? "R3" : "R4";
    exp_rd = '0;
    if (!wr) for (int k = 0; k < nb; k++) begin
      idx = 8'(addr + 32'(k));
      exp_rd[8*k +: 8] = mem[idx];
    end
    @(negedge clk);
    chk("R10 ready while idle", {31'd0, req_ready}, 32'd1);
    chk("R8 strobes idle", {30'd0, bus_rd_n, bus_wr_n}, 32'd3);
    req_valid = 1'b1; req_write = wr; req_io = io; req_size = sz;
    req_addr = addr; req_wdata = wd;
    for (int c = 0; c < ncyc; c++) begin
      for (int w = 0; w <= waitn; w++) begin
        @(negedge clk);
        req_valid = 1'b0;
        req_wdata = 32'hDEAD_BEEF;
        ea = {addr[31:2], 2'b00} + 32'(4 * c);
        if (io) ea = ea & 32'h0000_FFFF;
        chk((c == 1) ? "R5 second address" : "R1 aligned address", bus_addr, ea);
        exp_be = '0;
        for (int l = 0; l < 4; l++) begin
          rel = 4 * c + l - ofs;
          if (rel >= 0 && rel < nb) begin
            exp_be[l] = 1'b1;
            idx = 8'(addr + 32'(rel));
            bus_rdata[8*l +: 8] = mem[idx];
            if (wr) chk("R6 store lane", {24'd0, bus_wdata[8*l +: 8]}, {24'd0, wd[8*rel +: 8]});
          end else begin
            bus_rdata[8*l +: 8] = 8'hA5;
          end
        end
        chk({ctag, " enables / cycle count"}, {28'd0, bus_be}, exp_be);
        chk("R8 strobe pattern", {30'd0, bus_rd_n, bus_wr_n}, wr ? 32'd2 : 32'd1);
        chk("R11 space select", {31'd0, bus_io}, {31'd0, io});
        chk("R10 busy handshake", {30'd0, req_ready, done}, 32'd0);
        bus_ack = (w == waitn);
        if (wr && bus_ack) for (int l = 0; l < 4; l++) begin
          rel = 4 * c + l - ofs;
          if (rel >= 0 && rel < nb) begin
            idx = 8'(addr + 32'(rel));
            mem[idx] = wd[8*rel +: 8];
          end
        end
      end
    end
    @(negedge clk);
    bus_ack = 1'b0;
    bus_rdata = 32'h5A5A_5A5A;
    chk({ctag, " R10 done after final cycle"}, {31'd0, done}, 32'd1);
    chk("R7 returned data", done_rdata, exp_rd);
    chk("R8 strobes released", {30'd0, bus_rd_n, bus_wr_n}, 32'd3);
    @(negedge clk);
    chk("R10 done one cycle", {31'd0, done}, 32'd0);
  endtask

  initial begin
    #(100000 * 5ns);
    if (!finished) begin
      errors++;
      $display("FAIL R10 watchdog: actual hung expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 8'(i * 37 + 11);
    rst_n = 1'b0; req_valid = 1'b0; req_write = 1'b0; req_io = 1'b0;
    req_size = 2'd0; req_addr = '0; req_wdata = '0;
    bus_rdata = '0; bus_ack = 1'b0;
    repeat (3) @(negedge clk);
    // R12 reset state
    chk("R12 ready in reset", {31'd0, req_ready}, 32'd1);
    chk("R12 strobes in reset", {30'd0, bus_rd_n, bus_wr_n}, 32'd3);
    chk("R12 enables in reset", {28'd0, bus_be}, 32'd0);
    chk("R12 done in reset", {31'd0, done}, 32'd0);
    rst_n = 1'b1;
    // byte loads and stores at all offsets (R2)
    for (int o = 0; o < 4; o++) xfer(0, 0, 2'd0, 32'h10 + 32'(o), 32'h0, o % 2);
    for (int o = 0; o < 4; o++) xfer(1, 0, 2'd0, 32'h20 + 32'(o), 32'h0000_00C0 + 32'(o), 0);
    for (int o = 0; o < 4; o++) xfer(0, 0, 2'd0, 32'h20 + 32'(o), 32'h0, 0);
    // two-byte accesses, offset 3 splits (R3)
    for (int o = 0; o < 4; o++) xfer(0, 0, 2'd1, 32'h30 + 32'(o), 32'h0, 1);
    for (int o = 0; o < 4; o++) xfer(1, 0, 2'd1, 32'h40 + 32'(4 * o + o), 32'hFF00_1234 + 32'(o), 0);
    xfer(0, 0, 2'd1, 32'h47, 32'h0, 0);
    // four-byte accesses, any misalignment splits (R4, R5, R6, R7)
    for (int o = 0; o < 4; o++) xfer(0, 0, 2'd2, 32'h50 + 32'(o), 32'h0, o);
    for (int o = 0; o < 4; o++) xfer(1, 0, 2'd2, 32'h60 + 32'(8 * o + o), 32'h8877_6655 ^ 32'(o), 2);
    for (int o = 0; o < 4; o++) xfer(0, 0, 2'd2, 32'h60 + 32'(8 * o + o), 32'h0, 0);
    xfer(0, 0, 2'd3, 32'h6B, 32'h0, 1);
    // I/O space (R11), including a split near the window top
    xfer(1, 1, 2'd2, 32'hABCD_0082, 32'h0BAD_F00D, 1);
    xfer(0, 1, 2'd2, 32'hABCD_0082, 32'h0, 0);
    xfer(0, 1, 2'd1, 32'h1234_FF7B, 32'h0, 3);
    // long hold before acknowledge (R9)
    xfer(0, 0, 2'd2, 32'hF3, 32'h0, 6);
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule